// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register-port front end of an eight-level, legacy-style programmable interrupt controller. Software reaches it through a byte-wide port with a single address bit `a0`. Writes are decoded in one of two ways. While an initialization sequence is in progress, writes at `a0 = 1` are taken as initialization words. Once the controller is ready, the same address loads the mask. Writes at `a0 = 0` either start a new initialization or carry an operation command. An operation command can end a service routine, change the priority rotation, select which register a read returns, or turn special mask mode on or off.

A small priority resolver sits behind the decoder. It holds the request, in-service and mask registers and the current lowest-priority level. It detects rising edges on `req_in` and raises `int_out` with a vector equal to the programmed base plus the winning level. Reads return the mask, the request register or the in-service register. A read can also be a one-shot poll, which reports the winning level and acknowledges it in the same access. A poll read is the only acknowledge path this block has.

Top module: `intc_cmd_seq`

## Requirements
- R1: After reset the mask reads 0xFF, `int_out` is low, and the controller is not ready.
- R2: A write at `a0=0` with bit 4 set starts initialization. It clears the request register, the read select, the poll flag and special mask mode. It also sets the mask to 0x00, sets the lowest-priority level to 7 and makes the controller not ready.
- R3: The first initialization word is accepted only when bit 1 (single mode) is 0 and bit 0 (fourth word needed) is 1. If the word is rejected, later writes at `a0=1` are not taken as initialization words and the controller stays not ready.
- R4: The second word, written at `a0=1`, sets the vector base to the written value AND 0xF8. `vector_out` equals the base plus the winning level.
- R5: The third word has no effect. The fourth word completes initialization only if its bit 0 is set. Its bit 1 turns on auto end-of-interrupt, so an acknowledge does not set the in-service bit. Its bit 4 turns on special fully nested mode, and only on the master: an in-service cascade level (level 2) then does not block other levels.
- R6: When the controller is ready, a write at `a0=1` loads the mask. When it is not ready, the mask changes only through R2.
- R7: A write at `a0=0` with bit 4 = 0 and bit 3 = 1 is a read/mask command. Its bit 5 sets special mask mode only if bit 6 is also set. While special mask mode is on, in-service levels do not block any request.
- R8: A write at `a0=0` with bits 4 and 3 = 0 is an EOI/rotation command. When bit 5 is set it ends service, and the level whose in-service bit is cleared is chosen as follows:
  - If bit 6 is set, the level is given in bits 2:0.
  - Otherwise it is the highest-priority in-service level.
  - In special mask mode, masked levels are skipped when choosing that level.
- R9: Bit 7 of the EOI/rotation command sets rotation. With rotation on, an EOI makes the ended level the lowest priority. A command with bits 6 and 7 set and bit 5 clear makes the level in bits 2:0 the lowest priority. Priority runs upward from the level just above the lowest, wrapping at 7.
- R10: In a read/mask command, bit 1 gates updates of the read select (bit 0: 1 selects in-service, 0 selects request) and of the poll flag (bit 2). The next read after a poll clears the flag. It returns 0x80 OR the winning level and acknowledges that level: the request bit is cleared and the in-service bit is set unless auto-EOI is on. If no level wins, it returns 0x00.
- R11: A non-poll read at `a0=1` returns the mask. At `a0=0` it returns the in-service or the request register, as the read select chooses. `rdata` is valid on the cycle after `rd_en`.
- R12: A rising edge on `req_in` sets the request bit only while the controller is ready.
- R13: `int_out` is high when the controller is ready and an unmasked request is pending with no in-service level at equal or higher priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe; ignored while `wr_en` is high |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_in | input | 8 | Interrupt request lines, edge sensitive |
| int_out | output | 1 | Interrupt pending to the processor |
| vector_out | output | 8 | Vector base plus winning level |

## Verification
Most internal faults show up within one or two port accesses. A wrong initialization-word counter makes the following mask write read back wrongly. A wrong base shifts `vector_out` on the first request. A corrupted lowest-priority level or a wrong in-service bit changes which level `vector_out` reports, or whether `int_out` rises, in the cycle right after the command write. Rotation and special-mask errors only appear once two levels compete, so the tests set up pairs of pending requests with an in-service level between them. Auto-EOI is checked by reading the in-service register back after a poll acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_W2   = 2'd1,
      ST_W3   = 2'd2,
      ST_W4   = 2'd3
   } init_stage_t;

   // bit positions of command bytes (decoded by software, so fixed)
   localparam int B_INIT   = 4;
   localparam int B_OCW3   = 3;
   localparam int B_SINGLE = 1;
   localparam int B_NEED4  = 0;
   localparam int B_UPM    = 0;
   localparam int B_AUTO   = 1;
   localparam int B_SFN    = 4;
   localparam int B_ROT    = 7;
   localparam int B_SPEC   = 6;
   localparam int B_EOI    = 5;
   localparam int B_ESM    = 6;
   localparam int B_SMV    = 5;
   localparam int B_POLL   = 2;
   localparam int B_RDEN   = 1;
   localparam int B_RDISR  = 0;

   typedef struct packed {
      logic mask_wr;
      logic ocw2;
      logic ocw3;
      logic eoi;
      logic specific;
      logic rotate;
      logic esm;
      logic smv;
      logic rden;
      logic rdisr;
      logic poll;
   } cmd_t;

endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
   import intc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LVL_W     = 3,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   output logic              init_start,
   output init_stage_t       stage,
   output logic              ready,
   output logic [DATA_W-1:0] base,
   output logic              aeoi,
   output logic              sfn
);

   localparam logic [DATA_W-1:0] BASE_KEEP = {DATA_W{1'b1}} << LVL_W;

   logic word_wr;
   logic word1_ok;
   logic word4_ok;

   assign init_start = wr_en && !a0 && wdata[B_INIT];
   assign word_wr    = wr_en && a0;
   assign word1_ok   = !wdata[B_SINGLE] && wdata[B_NEED4];
   assign word4_ok   = word_wr && (stage == ST_W4) && wdata[B_UPM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= ST_IDLE;
         ready <= 1'b0;
         base  <= '0;
         aeoi  <= 1'b0;
      end else if (init_start) begin
         ready <= 1'b0;
         stage <= word1_ok ? ST_W2 : ST_IDLE;
      end else if (word_wr) begin
         unique case (stage)
            ST_W2: begin
               base  <= wdata & BASE_KEEP;
               stage <= ST_W3;
            end
            ST_W3: stage <= ST_W4;
            ST_W4: begin
               if (word4_ok) begin
                  aeoi  <= aeoi | wdata[B_AUTO];
                  ready <= 1'b1;
                  stage <= ST_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   generate
      if (IS_MASTER) begin : g_sfn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sfn <= 1'b0;
            else if (!init_start && word4_ok && wdata[B_SFN])
               sfn <= 1'b1;
         end
      end else begin : g_no_sfn
         assign sfn = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/intc_ocw_decode.sv
module intc_ocw_decode
   import intc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              wr_en,
   input  logic              a0,
   input  logic              ready,
   input  logic [DATA_W-1:0] wdata,
   output cmd_t              cmd
);

   logic op_wr;

   assign op_wr = wr_en && !a0 && !wdata[B_INIT] && ready;

   always_comb begin
      cmd          = '0;
      cmd.mask_wr  = wr_en && a0 && ready;
      cmd.ocw3     = op_wr && wdata[B_OCW3];
      cmd.ocw2     = op_wr && !wdata[B_OCW3];
      cmd.eoi      = wdata[B_EOI];
      cmd.specific = wdata[B_SPEC];
      cmd.rotate   = wdata[B_ROT];
      cmd.esm      = wdata[B_ESM];
      cmd.smv      = wdata[B_SMV];
      cmd.rden     = wdata[B_RDEN];
      cmd.rdisr    = wdata[B_RDISR];
      cmd.poll     = wdata[B_POLL];
   end

endmodule

// File: rtl/intc_resolver_stub.sv
module intc_resolver_stub
   import intc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LEVELS      = 8,
   parameter int LVL_W       = 3,
   parameter int CASCADE_LVL = 2,
   parameter logic [LEVELS-1:0] RESET_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_start,
   input  logic              ready,
   input  logic              aeoi,
   input  logic              sfn,
   input  cmd_t              cmd,
   input  logic [LEVELS-1:0] wdata,
   input  logic              rd_go,
   input  logic              a0,
   input  logic [LEVELS-1:0] req_in,
   output logic [DATA_W-1:0] rdata,
   output logic              win_valid,
   output logic [LVL_W-1:0]  win_idx,
   output logic [LEVELS-1:0] mask_q,
   output logic [LEVELS-1:0] request_q,
   output logic [LEVELS-1:0] service_q
);

   localparam logic [LEVELS-1:0] CASC_BIT = LEVELS'(1) << CASCADE_LVL;
   localparam logic [DATA_W-1:0] POLL_FLAG = DATA_W'(1) << (DATA_W-1);

   logic [LVL_W-1:0]  lowprio, low_n;
   logic              smm, smm_n;
   logic              rd_isr, ris_n;
   logic              poll, poll_n;
   logic              rotate, rot_n;
   logic [LEVELS-1:0] req_prev;
   logic [LEVELS-1:0] req_n, svc_n, mask_n;
   logic [DATA_W-1:0] rdata_n;
   logic [LEVELS-1:0] stop_vec, isr_cand, rising;
   logic [LVL_W:0]    win_pick, isr_pick;
   logic [LVL_W-1:0]  eoi_lvl;
   logic              eoi_hit;

   // scan levels upward from the one above lowprio; a set stop bit ends the scan
   function automatic logic [LVL_W:0] pick_level(
      input logic [LEVELS-1:0] cand,
      input logic [LEVELS-1:0] stop,
      input logic [LVL_W-1:0]  low
   );
      logic [LVL_W-1:0] idx;
      logic             done;
      logic [LVL_W:0]   res;
      res  = '0;
      done = 1'b0;
      for (int i = 0; i < LEVELS; i++) begin
         idx = low + LVL_W'(i + 1);
         if (!done) begin
            if (stop[idx]) begin
               done = 1'b1;
            end else if (cand[idx]) begin
               res  = {1'b1, idx};
               done = 1'b1;
            end
         end
      end
      return res;
   endfunction

   assign rising   = req_in & ~req_prev;
   assign stop_vec = smm ? '0 : (service_q & ~(sfn ? CASC_BIT : '0));
   assign isr_cand = service_q & ~(smm ? mask_q : '0);
   assign win_pick = pick_level(request_q & ~mask_q, stop_vec, lowprio);
   assign isr_pick = pick_level(isr_cand, '0, lowprio);
   assign win_valid = win_pick[LVL_W];
   assign win_idx   = win_pick[LVL_W-1:0];
   assign eoi_lvl   = cmd.specific ? wdata[LVL_W-1:0] : isr_pick[LVL_W-1:0];
   assign eoi_hit   = cmd.specific || isr_pick[LVL_W];

   always_comb begin
      req_n   = request_q;
      svc_n   = service_q;
      mask_n  = mask_q;
      low_n   = lowprio;
      smm_n   = smm;
      ris_n   = rd_isr;
      poll_n  = poll;
      rot_n   = rotate;
      rdata_n = rdata;

      if (init_start) begin
         req_n  = '0;
         mask_n = '0;
         low_n  = '1;
         smm_n  = 1'b0;
         ris_n  = 1'b0;
         poll_n = 1'b0;
      end

      if (cmd.mask_wr)
         mask_n = wdata;

      if (cmd.ocw3) begin
         if (cmd.esm)
            smm_n = cmd.smv;
         if (cmd.rden) begin
            ris_n  = cmd.rdisr;
            poll_n = cmd.poll;
         end
      end

      if (cmd.ocw2) begin
         rot_n = cmd.rotate;
         if (cmd.eoi) begin
            if (eoi_hit) begin
               svc_n[eoi_lvl] = 1'b0;
               if (cmd.rotate)
                  low_n = eoi_lvl;
            end
         end else if (cmd.specific && cmd.rotate) begin
            low_n = wdata[LVL_W-1:0];
         end
      end

      if (rd_go) begin
         if (poll) begin
            poll_n = 1'b0;
            if (win_valid) begin
               rdata_n        = POLL_FLAG | DATA_W'(win_idx);
               req_n[win_idx] = 1'b0;
               if (aeoi) begin
                  if (rotate)
                     low_n = win_idx;
               end else begin
                  svc_n[win_idx] = 1'b1;
               end
            end else begin
               rdata_n = '0;
            end
         end else if (a0) begin
            rdata_n = DATA_W'(mask_q);
         end else begin
            rdata_n = DATA_W'(rd_isr ? service_q : request_q);
         end
      end

      if (ready)
         req_n = req_n | rising;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         request_q <= '0;
         service_q <= '0;
         mask_q    <= RESET_MASK;
         lowprio   <= '1;
         smm       <= 1'b0;
         rd_isr    <= 1'b0;
         poll      <= 1'b0;
         rotate    <= 1'b0;
         rdata     <= '0;
         req_prev  <= '0;
      end else begin
         request_q <= req_n;
         service_q <= svc_n;
         mask_q    <= mask_n;
         lowprio   <= low_n;
         smm       <= smm_n;
         rd_isr    <= ris_n;
         poll      <= poll_n;
         rotate    <= rot_n;
         rdata     <= rdata_n;
         req_prev  <= req_in;
      end
   end

endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
   import intc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LEVELS      = 8,
   parameter int CASCADE_LVL = 2,
   parameter bit IS_MASTER   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [LEVELS-1:0] req_in,
   output logic              int_out,
   output logic [DATA_W-1:0] vector_out
);

   localparam int LVL_W = $clog2(LEVELS);

   generate
      if (LEVELS != DATA_W) begin : g_bad_width
         $error("LEVELS must equal DATA_W");
      end
      if ((1 << LVL_W) != LEVELS) begin : g_bad_levels
         $error("LEVELS must be a power of two");
      end
      if (CASCADE_LVL >= LEVELS) begin : g_bad_cascade
         $error("CASCADE_LVL out of range");
      end
   endgenerate

   logic              init_start;
   init_stage_t       stage;
   logic              ready;
   logic [DATA_W-1:0] base;
   logic              aeoi;
   logic              sfn;
   cmd_t              cmd;
   logic              rd_go;
   logic              win_valid;
   logic [LVL_W-1:0]  win_idx;
   logic [LEVELS-1:0] mask_q;
   logic [LEVELS-1:0] request_q;
   logic [LEVELS-1:0] service_q;

   assign rd_go = rd_en && !wr_en;

   intc_init_seq #(
      .DATA_W   (DATA_W),
      .LVL_W    (LVL_W),
      .IS_MASTER(IS_MASTER)
   ) u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .a0        (a0),
      .wdata     (wdata),
      .init_start(init_start),
      .stage     (stage),
      .ready     (ready),
      .base      (base),
      .aeoi      (aeoi),
      .sfn       (sfn)
   );

   intc_ocw_decode #(
      .DATA_W(DATA_W)
   ) u_dec (
      .wr_en(wr_en),
      .a0   (a0),
      .ready(ready),
      .wdata(wdata),
      .cmd  (cmd)
   );

   intc_resolver_stub #(
      .DATA_W     (DATA_W),
      .LEVELS     (LEVELS),
      .LVL_W      (LVL_W),
      .CASCADE_LVL(CASCADE_LVL)
   ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_start(init_start),
      .ready     (ready),
      .aeoi      (aeoi),
      .sfn       (sfn),
      .cmd       (cmd),
      .wdata     (wdata[LEVELS-1:0]),
      .rd_go     (rd_go),
      .a0        (a0),
      .req_in    (req_in),
      .rdata     (rdata),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .mask_q    (mask_q),
      .request_q (request_q),
      .service_q (service_q)
   );

   assign int_out    = ready && win_valid;
   assign vector_out = base + DATA_W'(win_idx);

endmodule

// File: rtl/intc_cmd_seq_chk.sv
module intc_cmd_seq_chk
   import intc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEVELS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              a0,
   input logic [DATA_W-1:0] wdata,
   input logic              int_out,
   input logic [DATA_W-1:0] vector_out,
   input logic              ready,
   input init_stage_t       stage,
   input logic [DATA_W-1:0] base,
   input logic [LEVELS-1:0] mask_q,
   input logic [LEVELS-1:0] request_q
);

   localparam int LVL_W = $clog2(LEVELS);

   logic start_wr;
   assign start_wr = wr_en && !a0 && wdata[B_INIT];

   a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (!ready && mask_q == '0 && request_q == '0));

   a_r3_word1_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && (wdata[B_SINGLE] || !wdata[B_NEED4])) |=> (stage == ST_IDLE));

   a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      base[LVL_W-1:0] == '0);

   a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (stage == ST_IDLE));

   a_r6_mask_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !start_wr) |=> $stable(mask_q));

   a_r12_no_req_unready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (request_q == '0));

   a_r13_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (vector_out[DATA_W-1:LVL_W] == base[DATA_W-1:LVL_W]));

endmodule

bind intc_cmd_seq intc_cmd_seq_chk #(
   .DATA_W(DATA_W),
   .LEVELS(LEVELS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .a0        (a0),
   .wdata     (wdata),
   .int_out   (int_out),
   .vector_out(vector_out),
   .ready     (ready),
   .stage     (stage),
   .base      (base),
   .mask_q    (mask_q),
   .request_q (request_q)
);

// File: tb/intc_cmd_seq_test.sv
module intc_cmd_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic       a0 = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] req_in = '0;
   logic       int_out;
   logic [7:0] vector_out;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   intc_cmd_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .a0        (a0),
      .wdata     (wdata),
      .rdata     (rdata),
      .req_in    (req_in),
      .int_out   (int_out),
      .vector_out(vector_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic adr, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; a0 = adr; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic adr, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; a0 = adr;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic set_req(input int idx, input logic val);
      @(negedge clk);
      req_in[idx] = val;
      @(negedge clk);
   endtask

   task automatic init_seq(input logic [7:0] w2, input logic [7:0] w4);
      wr(1'b0, 8'h11);
      wr(1'b1, w2);
      wr(1'b1, 8'h00);
      wr(1'b1, w4);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
      rd(1'b1, v);
      chk("R1 mask after reset", v, 8'hFF);
   endtask

   task automatic t_unready;
      logic [7:0] v;
      wr(1'b1, 8'h00);
      rd(1'b1, v);
      chk("R6 mask write ignored while not ready", v, 8'hFF);
      set_req(3, 1'b1);
      chk("R12 no int while not ready", {7'd0, int_out}, 8'h00);
   endtask

   task automatic t_bad_word1;
      logic [7:0] v;
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h40);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h01);
      wr(1'b1, 8'h5A);
      rd(1'b1, v);
      chk("R3 rejected word1 leaves controller not ready", v, 8'h00);
      chk("R2 init start cleared mask", v, 8'h00);
   endtask

   task automatic t_good_init;
      logic [7:0] v;
      init_seq(8'h27, 8'h01);
      rd(1'b0, v);
      chk("R12 edge before ready not latched", v, 8'h00);
      wr(1'b1, 8'h08);
      rd(1'b1, v);
      chk("R6 mask load when ready", v, 8'h08);
      chk("R5 ready after word4", v, 8'h08);
      wr(1'b1, 8'h00);
   endtask

   task automatic t_request;
      set_req(3, 1'b0);
      set_req(3, 1'b1);
      chk("R13 int_out on pending level 3", {7'd0, int_out}, 8'h01);
      chk("R4 vector base 0x20 plus level 3", vector_out, 8'h23);
      set_req(5, 1'b1);
      chk("R9 level 3 outranks 5 at default priority", vector_out, 8'h23);
   endtask

   task automatic t_poll;
      logic [7:0] v;
      wr(1'b0, 8'h0E);
      rd(1'b0, v);
      chk("R10 poll returns 0x80|3", v, 8'h83);
      rd(1'b0, v);
      chk("R11 request read after poll", v, 8'h20);
      wr(1'b0, 8'h0B);
      rd(1'b0, v);
      chk("R11 in-service read", v, 8'h08);
      chk("R13 lower level blocked by in-service", {7'd0, int_out}, 8'h00);
      rd(1'b1, v);
      chk("R11 mask read", v, 8'h00);
   endtask

   task automatic t_eoi;
      logic [7:0] v;
      wr(1'b0, 8'h20);
      chk("R8 nonspecific EOI releases level 5", vector_out, 8'h25);
      chk("R8 int_out after EOI", {7'd0, int_out}, 8'h01);
      rd(1'b0, v);
      chk("R8 in-service empty after EOI", v, 8'h00);
   endtask

   task automatic t_rotate;
      logic [7:0] v;
      wr(1'b0, 8'h0E);
      rd(1'b0, v);
      chk("R10 poll returns 0x80|5", v, 8'h85);
      wr(1'b0, 8'hE5);
      chk("R8 specific EOI leaves nothing pending", {7'd0, int_out}, 8'h00);
      @(negedge clk);
      req_in[4] = 1'b1; req_in[6] = 1'b1;
      @(negedge clk);
      chk("R9 rotate on EOI makes 6 highest", vector_out, 8'h26);
      wr(1'b0, 8'hC6);
      chk("R9 set priority lowest=6 makes 4 win", vector_out, 8'h24);
   endtask

   task automatic t_smm;
      logic [7:0] v;
      wr(1'b0, 8'h0E);
      rd(1'b0, v);
      chk("R10 poll returns 0x80|4", v, 8'h84);
      chk("R13 level 6 blocked by in-service 4", {7'd0, int_out}, 8'h00);
      wr(1'b1, 8'h10);
      wr(1'b0, 8'h68);
      chk("R7 special mask lets level 6 through", vector_out, 8'h26);
      chk("R7 int_out in special mask mode", {7'd0, int_out}, 8'h01);
      wr(1'b0, 8'h28);
      chk("R7 special mask bit ignored without enable", {7'd0, int_out}, 8'h01);
      wr(1'b0, 8'h48);
      chk("R7 special mask cleared", {7'd0, int_out}, 8'h00);
   endtask

   task automatic t_reinit_aeoi;
      logic [7:0] v;
      wr(1'b0, 8'h11);
      chk("R2 int_out low after init start", {7'd0, int_out}, 8'h00);
      rd(1'b1, v);
      chk("R2 mask zero after init start", v, 8'h00);
      wr(1'b1, 8'h40);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h03);
      wr(1'b0, 8'h0E);
      rd(1'b0, v);
      chk("R10 poll with nothing pending", v, 8'h00);
      rd(1'b0, v);
      chk("R2 request cleared by init start", v, 8'h00);
      set_req(2, 1'b1);
      chk("R4 vector base 0x40 plus level 2", vector_out, 8'h42);
      wr(1'b0, 8'h0E);
      rd(1'b0, v);
      chk("R10 poll returns 0x80|2", v, 8'h82);
      wr(1'b0, 8'h0B);
      rd(1'b0, v);
      chk("R5 auto EOI leaves in-service unchanged", v, 8'h10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unready();
      t_bad_word1();
      t_good_init();
      t_request();
      t_poll();
      t_eoi();
      t_rotate();
      t_smm();
      t_reinit_aeoi();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule